// File: doc/BRIEF.md
# Low-Power Mode Transition Controller

This block holds the operating mode of a small processor core and decides every change between running and power-saving modes. It samples the reset and standby pins, a one-cycle strobe raised when the core executes its sleep instruction, the power-control bits (standby select, subclock-target select, low-speed-on-wake, direct-transfer) and the interrupt-accepted flags from the interrupt controller. From these it produces a mode code, a main/subclock select, a halted flag, a busy flag while the oscillator settles, and a one-cycle wake strobe.

The sleep strobe can lead to several places: a light sleep on the main clock, a deep software standby, a watch mode on the subclock, a subclock sleep, or a direct switch between the main clock and the subclock. The bit combination picks the target. Each halted mode has its own set of interrupts that can end it. When the block leaves software standby, or switches from the subclock back to the main clock, it first waits for a settling time chosen by a 3-bit code.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `stby_n_i` is low, the next mode is hardware standby (code 0), whatever the current state or other inputs.
- R2: While `stby_n_i` is high and `res_n_i` is low, the next mode is reset (code 1). When the block leaves hardware standby, it passes through reset. When it is in reset and both pins are high, it moves to high-speed (code 2).
- R3: In the running state, the next mode is high-speed (code 2) when `sck_i` is 0 and medium-speed (code 3) otherwise.
- R4: In high- or medium-speed, a sleep strobe with ssby=0 and lson=0 enters sleep (code 4). Any set bit of `irq_ack_i` returns the block to the running state (mode chosen as in R3). With no accepted flag, the mode stays the same.
- R5: In running, a sleep strobe with ssby=1, pss=0 and lson=0 enters software standby (code 5). Only accepted bits 0 (NMI), 1–3 (IRQ0–IRQ2), 7 (IRQ6) or 8 (IRQ7) start a wake. After the settling time, the block returns to running.
- R6: A sleep strobe with ssby=1, pss=1 and dton=0 enters watch (code 6), but only from high-speed. Bits 0,1,2,3,7,8 or 10 (WDT1) wake it. The block then goes to high-speed (code 2) when lson=0 and to subactive (code 7) when lson=1.
- R7: In subactive, a sleep strobe with ssby=0, pss=1 and lson=1 enters subsleep (code 8). Any of bits 0–12 (NMI, IRQ0–7, WDT0 at 9, WDT1 at 10, TMR0 at 11, TMR1 at 12) returns the block to subactive.
- R8: A sleep strobe with ssby=1, pss=1, dton=1 and lson=1 moves high-speed straight to subactive. A sleep strobe with ssby=1, pss=1, dton=1 and lson=0 in subactive starts settling, then moves to high-speed.
- R9: The settling time is 2^(SETTLE_BASE+sts) cycles, using the `sts_i` value latched at the start. `settle_busy_o` is high for exactly that many cycles. The mode changes on the edge where busy falls. Interrupts and sleep strobes have no effect during settling.
- R10: A sleep strobe whose bits match no transition for the current mode leaves the mode unchanged. This includes a watch request from medium-speed. Sleep strobes are ignored in halted modes.
- R11: `wake_o` is high for exactly one cycle each time the block leaves sleep, software standby, watch or subsleep because of a wake. It is high at no other time.
- R12: `clk_sub_o` is high in watch, subactive and subsleep. `halted_o` is high in sleep, software standby, watch and subsleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| res_n_i | input | 1 | Reset pin, active low, sampled on the clock |
| stby_n_i | input | 1 | Hardware standby pin, active low, sampled on the clock |
| sleep_i | input | 1 | One-cycle strobe for the sleep instruction |
| ssby_i | input | 1 | Standby select bit |
| pss_i | input | 1 | Subclock target select bit |
| lson_i | input | 1 | Low-speed (subactive) on wake / entry bit |
| dton_i | input | 1 | Direct clock transfer bit |
| sck_i | input | 3 | Main clock divider select; 0 means high-speed |
| sts_i | input | 3 | Settling time select |
| irq_ack_i | input | 13 | Accepted-interrupt flags, bit positions as in R5–R7 |
| mode_o | output | 4 | Current mode code |
| clk_sub_o | output | 1 | 1 when running from the subclock |
| halted_o | output | 1 | 1 in a program-halted power-down mode |
| settle_busy_o | output | 1 | Oscillator settling counter running |
| wake_o | output | 1 | One-cycle pulse on leaving a power-down mode |

## Verification
The assertions assume that the reset pin has been seen low at least once before they take effect. They also assume that every input is steady across each rising edge, because the pins are sampled and not treated as asynchronous. The bench holds reset low for its first cycles and changes all inputs only on the falling edge. The random phase keeps reset and standby pulses rare, so the long settling windows and the wake paths are actually reached between them.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    localparam int IRQ_W = 13;

    typedef enum logic [3:0] {
        PM_HWSTBY = 4'd0,
        PM_RESET  = 4'd1,
        PM_HIGH   = 4'd2,
        PM_MEDIUM = 4'd3,
        PM_SLEEP  = 4'd4,
        PM_SWSTBY = 4'd5,
        PM_WATCH  = 4'd6,
        PM_SUBACT = 4'd7,
        PM_SUBSLP = 4'd8
    } pm_mode_e;

    typedef enum logic [2:0] {
        SL_NONE,
        SL_SLEEP,
        SL_SWSTBY,
        SL_WATCH,
        SL_TO_SUB,
        SL_SUBSLP,
        SL_TO_HIGH
    } sl_act_e;

    // wake sets: external pins + NMI, that plus WDT1, everything
    localparam logic [IRQ_W-1:0] MASK_EXT   = 13'h018F;
    localparam logic [IRQ_W-1:0] MASK_WATCH = 13'h058F;
    localparam logic [IRQ_W-1:0] MASK_ALL   = 13'h1FFF;

    typedef struct packed {
        pm_mode_e mode;
        logic     wake;
    } pmc_state_t;

endpackage

// File: rtl/pmc_sleep_decode.sv
module pmc_sleep_decode
    import pmc_pkg::*;
(
    input  pm_mode_e mode_i,
    input  logic     ssby_i,
    input  logic     pss_i,
    input  logic     lson_i,
    input  logic     dton_i,
    output sl_act_e  act_o
);
    logic running;
    assign running = (mode_i == PM_HIGH) || (mode_i == PM_MEDIUM);

    always_comb begin
        act_o = SL_NONE;
        if (running) begin
            if (!ssby_i && !lson_i) begin
                act_o = SL_SLEEP;
            end else if (ssby_i && !pss_i && !lson_i) begin
                act_o = SL_SWSTBY;
            end else if (ssby_i && pss_i && !dton_i && (mode_i == PM_HIGH)) begin
                act_o = SL_WATCH;
            end else if (ssby_i && pss_i && dton_i && lson_i && (mode_i == PM_HIGH)) begin
                act_o = SL_TO_SUB;
            end
        end else if (mode_i == PM_SUBACT) begin
            if (!ssby_i && pss_i && lson_i) begin
                act_o = SL_SUBSLP;
            end else if (ssby_i && pss_i && dton_i && !lson_i) begin
                act_o = SL_TO_HIGH;
            end
        end
    end
endmodule

// File: rtl/pmc_wake_filter.sv
module pmc_wake_filter
    import pmc_pkg::*;
#(
    parameter int W = IRQ_W
) (
    input  pm_mode_e       mode_i,
    input  logic [W-1:0]   ack_i,
    output logic           wake_ok_o
);
    logic [W-1:0] mask;

    always_comb begin
        case (mode_i)
            PM_SLEEP:  mask = MASK_ALL[W-1:0];
            PM_SWSTBY: mask = MASK_EXT[W-1:0];
            PM_WATCH:  mask = MASK_WATCH[W-1:0];
            PM_SUBSLP: mask = MASK_ALL[W-1:0];
            default:   mask = '0;
        endcase
    end

    assign wake_ok_o = |(ack_i & mask);
endmodule

// File: rtl/pmc_settle_cnt.sv
module pmc_settle_cnt #(
    parameter int BASE = 8
) (
    input  logic       clk,
    input  logic       clr_i,
    input  logic       start_i,
    input  logic [2:0] sts_i,
    output logic       busy_o,
    output logic       done_o
);
    localparam int CW = BASE + 8;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          busy;
    } cnt_state_t;

    cnt_state_t cs_d, cs_q;
    logic [CW-1:0] one_w;
    logic [CW-1:0] load_w;

    assign one_w  = CW'(1);
    assign load_w = (one_w << (BASE + int'(sts_i))) - one_w;

    always_comb begin
        cs_d = cs_q;
        if (clr_i) begin
            cs_d.busy = 1'b0;
            cs_d.cnt  = '0;
        end else if (start_i) begin
            cs_d.busy = 1'b1;
            cs_d.cnt  = load_w;
        end else if (cs_q.busy) begin
            if (cs_q.cnt == '0) begin
                cs_d.busy = 1'b0;
            end else begin
                cs_d.cnt = cs_q.cnt - one_w;
            end
        end
    end

    always_ff @(posedge clk) begin
        cs_q <= cs_d;
    end

    assign busy_o = cs_q.busy;
    assign done_o = cs_q.busy && (cs_q.cnt == '0) && !clr_i;
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int SETTLE_BASE = 8
) (
    input  logic             clk,
    input  logic             res_n_i,
    input  logic             stby_n_i,
    input  logic             sleep_i,
    input  logic             ssby_i,
    input  logic             pss_i,
    input  logic             lson_i,
    input  logic             dton_i,
    input  logic [2:0]       sck_i,
    input  logic [2:0]       sts_i,
    input  logic [IRQ_W-1:0] irq_ack_i,
    output logic [3:0]       mode_o,
    output logic             clk_sub_o,
    output logic             halted_o,
    output logic             settle_busy_o,
    output logic             wake_o
);
    pmc_state_t st_d, st_q;
    sl_act_e    act;
    logic       wake_ok;
    logic       settle_start;
    logic       settle_busy;
    logic       settle_done;
    logic       settle_clr;
    pm_mode_e   run_sel;

    pmc_sleep_decode u_dec (
        .mode_i (st_q.mode),
        .ssby_i (ssby_i),
        .pss_i  (pss_i),
        .lson_i (lson_i),
        .dton_i (dton_i),
        .act_o  (act)
    );

    pmc_wake_filter #(.W(IRQ_W)) u_wflt (
        .mode_i    (st_q.mode),
        .ack_i     (irq_ack_i),
        .wake_ok_o (wake_ok)
    );

    assign settle_clr = !stby_n_i || !res_n_i;

    pmc_settle_cnt #(.BASE(SETTLE_BASE)) u_settle (
        .clk     (clk),
        .clr_i   (settle_clr),
        .start_i (settle_start),
        .sts_i   (sts_i),
        .busy_o  (settle_busy),
        .done_o  (settle_done)
    );

    assign run_sel = (sck_i == 3'd0) ? PM_HIGH : PM_MEDIUM;

    always_comb begin
        st_d         = st_q;
        st_d.wake    = 1'b0;
        settle_start = 1'b0;
        if (!stby_n_i) begin
            st_d.mode = PM_HWSTBY;
        end else if (!res_n_i || (st_q.mode == PM_HWSTBY)) begin
            st_d.mode = PM_RESET;
        end else begin
            case (st_q.mode)
                PM_RESET: st_d.mode = PM_HIGH;
                PM_HIGH, PM_MEDIUM: begin
                    st_d.mode = run_sel;
                    if (sleep_i) begin
                        case (act)
                            SL_SLEEP:  st_d.mode = PM_SLEEP;
                            SL_SWSTBY: st_d.mode = PM_SWSTBY;
                            SL_WATCH:  st_d.mode = PM_WATCH;
                            SL_TO_SUB: st_d.mode = PM_SUBACT;
                            default:   st_d.mode = st_q.mode;
                        endcase
                    end
                end
                PM_SLEEP: begin
                    if (wake_ok) begin
                        st_d.mode = run_sel;
                        st_d.wake = 1'b1;
                    end
                end
                PM_SWSTBY: begin
                    if (settle_busy) begin
                        if (settle_done) begin
                            st_d.mode = run_sel;
                            st_d.wake = 1'b1;
                        end
                    end else if (wake_ok) begin
                        settle_start = 1'b1;
                    end
                end
                PM_WATCH: begin
                    if (wake_ok) begin
                        st_d.mode = lson_i ? PM_SUBACT : PM_HIGH;
                        st_d.wake = 1'b1;
                    end
                end
                PM_SUBACT: begin
                    if (settle_busy) begin
                        if (settle_done) begin
                            st_d.mode = PM_HIGH;
                        end
                    end else if (sleep_i && (act == SL_SUBSLP)) begin
                        st_d.mode = PM_SUBSLP;
                    end else if (sleep_i && (act == SL_TO_HIGH)) begin
                        settle_start = 1'b1;
                    end
                end
                PM_SUBSLP: begin
                    if (wake_ok) begin
                        st_d.mode = PM_SUBACT;
                        st_d.wake = 1'b1;
                    end
                end
                default: st_d.mode = PM_RESET;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign mode_o        = st_q.mode;
    assign wake_o        = st_q.wake;
    assign settle_busy_o = settle_busy;
    assign clk_sub_o     = (st_q.mode == PM_WATCH) || (st_q.mode == PM_SUBACT)
                        || (st_q.mode == PM_SUBSLP);
    assign halted_o      = (st_q.mode == PM_SLEEP) || (st_q.mode == PM_SWSTBY)
                        || (st_q.mode == PM_WATCH) || (st_q.mode == PM_SUBSLP);
endmodule

// File: rtl/pmc_checker.sv
module pmc_checker
    import pmc_pkg::*;
(
    input logic             clk,
    input logic             res_n_i,
    input logic             stby_n_i,
    input logic [IRQ_W-1:0] irq_ack_i,
    input logic [3:0]       mode_o,
    input logic             halted_o,
    input logic             settle_busy_o,
    input logic             wake_o
);
    logic seen_q  = 1'b0;
    logic armed_q = 1'b0;

    always_ff @(posedge clk) begin
        if (!res_n_i) seen_q <= 1'b1;
        armed_q <= seen_q;
    end

    p_stby_r1: assert property (@(posedge clk) disable iff (!armed_q)
        !stby_n_i |=> (mode_o == PM_HWSTBY));

    p_reset_r2: assert property (@(posedge clk) disable iff (!armed_q)
        (stby_n_i && !res_n_i) |=> (mode_o == PM_RESET));

    p_release_r2: assert property (@(posedge clk) disable iff (!armed_q)
        (stby_n_i && res_n_i && mode_o == PM_RESET) |=> (mode_o == PM_HIGH));

    p_sleep_hold_r4: assert property (@(posedge clk) disable iff (!armed_q)
        (mode_o == PM_SLEEP && irq_ack_i == '0 && stby_n_i && res_n_i)
        |=> (mode_o == PM_SLEEP));

    p_watch_src_r6: assert property (@(posedge clk) disable iff (!armed_q)
        (mode_o == PM_WATCH && $past(mode_o) != PM_WATCH)
        |-> ($past(mode_o) == PM_HIGH));

    p_busy_mode_r9: assert property (@(posedge clk) disable iff (!armed_q)
        settle_busy_o |-> (mode_o == PM_SWSTBY || mode_o == PM_SUBACT));

    p_wake_single_r11: assert property (@(posedge clk) disable iff (!armed_q)
        wake_o |=> !wake_o);

    p_wake_exit_r11: assert property (@(posedge clk) disable iff (!armed_q)
        wake_o |-> ($past(halted_o) && !halted_o));
endmodule

bind pwr_mode_ctrl pmc_checker u_pmc_chk (
    .clk           (clk),
    .res_n_i       (res_n_i),
    .stby_n_i      (stby_n_i),
    .irq_ack_i     (irq_ack_i),
    .mode_o        (mode_o),
    .halted_o      (halted_o),
    .settle_busy_o (settle_busy_o),
    .wake_o        (wake_o)
);

// File: tb/tb_pwr_mode_ctrl.sv
module tb_pwr_mode_ctrl;
    localparam int BASE = 2;

    logic        clk = 1'b0;
    logic        res_n, stby_n, sleep, ssby, pss, lson, dton;
    logic [2:0]  sck, sts;
    logic [12:0] ack;
    logic [3:0]  mode;
    logic        clk_sub, halted, busy, wake;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // bench reference state
    int m_mode = 1;
    bit m_busy = 0;
    int m_cnt  = 0;
    bit m_wake = 0;

    always #5 clk = ~clk;

    pwr_mode_ctrl #(.SETTLE_BASE(BASE)) dut (
        .clk(clk), .res_n_i(res_n), .stby_n_i(stby_n), .sleep_i(sleep),
        .ssby_i(ssby), .pss_i(pss), .lson_i(lson), .dton_i(dton),
        .sck_i(sck), .sts_i(sts), .irq_ack_i(ack),
        .mode_o(mode), .clk_sub_o(clk_sub), .halted_o(halted),
        .settle_busy_o(busy), .wake_o(wake)
    );

    function automatic logic [12:0] wake_set(int md);
        case (md)
            4, 8:    return 13'h1FFF;
            5:       return 13'h018F;
            6:       return 13'h058F;
            default: return 13'h0000;
        endcase
    endfunction

    function automatic string tag_of(int md);
        case (md)
            0, 1:    return "R2";
            2, 3:    return "R3";
            4:       return "R4";
            5:       return "R5";
            6:       return "R6";
            7:       return "R8";
            default: return "R7";
        endcase
    endfunction

    function automatic bit exp_sub(int md);
        return (md == 6) || (md == 7) || (md == 8);
    endfunction

    function automatic bit exp_halt(int md);
        return (md == 4) || (md == 5) || (md == 6) || (md == 8);
    endfunction

    task automatic chk(string req, int got, int exp, string what);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic model_step();
        int  nm   = m_mode;
        bit  wk   = |(ack & wake_set(m_mode));
        int  run  = (sck == 0) ? 2 : 3;
        m_wake = 0;
        if (!stby_n) begin
            nm = 0; m_busy = 0;
        end else if (!res_n || m_mode == 0) begin
            nm = 1; m_busy = 0;
        end else begin
            case (m_mode)
                1: nm = 2;
                2, 3: begin
                    nm = run;
                    if (sleep) begin
                        nm = m_mode;
                        if (!ssby && !lson) nm = 4;
                        else if (ssby && !pss && !lson) nm = 5;
                        else if (ssby && pss && !dton && m_mode == 2) nm = 6;
                        else if (ssby && pss && dton && lson && m_mode == 2) nm = 7;
                    end
                end
                4: if (wk) begin nm = run; m_wake = 1; end
                5: begin
                    if (m_busy) begin
                        m_cnt--;
                        if (m_cnt == 0) begin m_busy = 0; nm = run; m_wake = 1; end
                    end else if (wk) begin
                        m_busy = 1; m_cnt = 1 << (BASE + int'(sts));
                    end
                end
                6: if (wk) begin nm = lson ? 7 : 2; m_wake = 1; end
                7: begin
                    if (m_busy) begin
                        m_cnt--;
                        if (m_cnt == 0) begin m_busy = 0; nm = 2; end
                    end else if (sleep && !ssby && pss && lson) begin
                        nm = 8;
                    end else if (sleep && ssby && pss && dton && !lson) begin
                        m_busy = 1; m_cnt = 1 << (BASE + int'(sts));
                    end
                end
                8: if (wk) begin nm = 7; m_wake = 1; end
                default: nm = 1;
            endcase
        end
        m_mode = nm;
    endtask

    task automatic tick();
        string t = tag_of(m_mode);
        model_step();
        @(posedge clk);
        @(negedge clk);
        chk(t, int'(mode), m_mode, "mode");
        chk("R9", int'(busy), int'(m_busy), "settle_busy");
        chk("R11", int'(wake), int'(m_wake), "wake");
        chk("R12", int'(clk_sub), int'(exp_sub(m_mode)), "clk_sub");
        chk("R12", int'(halted), int'(exp_halt(m_mode)), "halted");
    endtask

    task automatic set_bits(bit s, bit p, bit l, bit d);
        ssby = s; pss = p; lson = l; dton = d;
    endtask

    task automatic strobe();
        sleep = 1'b1; tick(); sleep = 1'b0;
    endtask

    task automatic irq(logic [12:0] v);
        ack = v; tick(); ack = '0;
    endtask

    initial begin
        #1_500_000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got 0 expected 1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int n;
        void'($urandom(32'd20240611));
        res_n = 0; stby_n = 1; sleep = 0; set_bits(0, 0, 0, 0);
        sck = 0; sts = 0; ack = '0;
        tick(); tick();
        chk("R2", int'(mode), 1, "reset mode");
        chk("R12", int'(halted), 0, "reset halted");
        res_n = 1; tick();
        chk("R2", int'(mode), 2, "release to high");

        sck = 3; tick();
        chk("R3", int'(mode), 3, "medium");
        sck = 0; tick();
        chk("R3", int'(mode), 2, "high");

        set_bits(0, 0, 0, 0); strobe();
        chk("R4", int'(mode), 4, "sleep entry");
        tick(); tick();
        chk("R4", int'(mode), 4, "sleep held without accept");
        irq(13'h1000);
        chk("R4", int'(mode), 2, "sleep wake by TMR1");
        chk("R11", int'(wake), 1, "wake pulse");
        tick();
        chk("R11", int'(wake), 0, "wake one cycle");

        set_bits(1, 0, 0, 0); strobe();
        chk("R5", int'(mode), 5, "swstby entry");
        irq(13'h0200);
        chk("R5", int'(busy), 0, "WDT0 ignored in swstby");
        chk("R5", int'(mode), 5, "WDT0 ignored mode");
        sts = 1; irq(13'h0001);
        sts = 7;
        n = 0;
        while (busy && n < 1000) begin n++; tick(); end
        chk("R9", n, 8, "settle length sts=1");
        chk("R5", int'(mode), 2, "swstby exit");
        chk("R11", int'(wake), 1, "swstby wake pulse");
        sts = 0;

        sck = 1; tick();
        set_bits(1, 1, 0, 0); strobe();
        chk("R10", int'(mode), 3, "watch from medium refused");
        sck = 0; tick();
        strobe();
        chk("R6", int'(mode), 6, "watch entry");
        chk("R12", int'(clk_sub), 1, "watch on subclock");
        irq(13'h0800);
        chk("R6", int'(mode), 6, "TMR0 ignored in watch");
        lson = 1; irq(13'h0400);
        chk("R6", int'(mode), 7, "watch wake to subactive");

        set_bits(0, 1, 1, 0); strobe();
        chk("R7", int'(mode), 8, "subsleep entry");
        irq(13'h0200);
        chk("R7", int'(mode), 7, "subsleep wake by WDT0");

        sts = 0; set_bits(1, 1, 0, 1); strobe();
        chk("R8", int'(busy), 1, "sub to high settling");
        n = 1;
        while (busy && n < 1000) begin
            chk("R8", int'(mode), 7, "mode held while settling");
            n++; tick();
        end
        chk("R9", n, 5, "settle length sts=0 plus start cycle");
        chk("R8", int'(mode), 2, "sub to high done");
        chk("R11", int'(wake), 0, "no wake on clock switch");

        set_bits(1, 1, 1, 1); strobe();
        chk("R8", int'(mode), 7, "high to sub direct");
        set_bits(1, 1, 0, 1); strobe();
        stby_n = 0; tick();
        chk("R1", int'(mode), 0, "standby during settling");
        res_n = 0; tick();
        chk("R1", int'(mode), 0, "standby over reset");
        stby_n = 1; tick();
        chk("R2", int'(mode), 1, "standby exit to reset");
        res_n = 1; tick();
        chk("R2", int'(mode), 2, "reset release");
        set_bits(0, 1, 1, 0); strobe();
        chk("R10", int'(mode), 2, "illegal strobe in high");

        for (int i = 0; i < 4000; i++) begin
            int r = $urandom % 400;
            stby_n = !(r == 0);
            res_n  = !(r == 1 || r == 2);
            sleep  = ($urandom % 6) == 0;
            set_bits(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
            sck = (($urandom % 4) == 0) ? 3'($urandom) : 3'd0;
            sts = 3'($urandom % 3);
            ack = (($urandom % 10) == 0) ? (13'd1 << ($urandom % 13)) : 13'd0;
            tick();
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule